// File: doc/BRIEF.md
# Table-Programmed Mealy Machine

This block is a finite state machine whose transitions and outputs are not built from fixed logic. Both are held in writable tables. One table gives the next state and the other gives the output word. Both are indexed by the pair made of the present state and the present input symbol. Changing the machine's behaviour therefore means rewriting table entries through a simple write port; the block itself does not change.

The next-state table is read on the clock edge. Its registered read data is the state, so a separate state register is not needed. The output table is read combinationally. The output word therefore follows the input symbol within the same cycle, which is the defining property of a Mealy machine.

The state and input widths are parameters, so the state count can be scaled from a handful up to 4096 or 65536 states. An advance-enable input can hold the machine in place without stalling the output path.

Top module: `tfsm_mealy`

## Requirements
- R1: Both tables are indexed by the address {cur_state, sym_in}, with the state in the upper STATE_BITS bits and the symbol in the lower INPUT_BITS bits. Each table has 2^(STATE_BITS+INPUT_BITS) entries, and tbl_addr uses the same layout.
- R2: While rst is high on a rising clock edge, cur_state becomes 0 at that edge. During reset, out_word shows the output-table entry at {0, sym_in}.
- R3: On a rising edge with rst low and adv_en high, cur_state takes the next-state-table entry at {cur_state, sym_in}.
- R4: out_word always equals the output-table entry at {cur_state, sym_in}, with no clock delay. A change on sym_in inside a cycle changes out_word inside that same cycle.
- R5: On an edge with adv_en low and rst low, cur_state keeps its value. out_word still follows sym_in.
- R6: With tbl_we high at a rising edge, the entry at tbl_addr is written. tbl_sel = 0 selects the next-state table and tbl_sel = 1 selects the output table. A next-state write never changes cur_state by itself.
- R7: When a write hits the entry being read at the same edge, the state transition uses the entry's old value. An output-table write appears on out_word only after the edge.
- R8: A next-state write stores tbl_wdata[STATE_BITS-1:0] and an output write stores tbl_wdata[OUTPUT_BITS-1:0]. tbl_wdata is max(STATE_BITS, OUTPUT_BITS) bits wide, and any bits above the selected width are ignored.
- R9: Reset takes priority over adv_en: rst high with adv_en low still clears cur_state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable; state holds when low |
| sym_in | input | INPUT_BITS | Present input symbol |
| out_word | output | OUTPUT_BITS | Output-table entry for {state, symbol} |
| cur_state | output | STATE_BITS | Present state |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | 0 = next-state table, 1 = output table |
| tbl_addr | input | STATE_BITS+INPUT_BITS | Write address {state, symbol} |
| tbl_wdata | input | max(STATE_BITS,OUTPUT_BITS) | Write data, low bits used |

## Verification
The bench attacks the same-edge collision, where an entry is rewritten in the very cycle it is read. A design that forwarded the new value would jump to the wrong state, and a design with a registered output lookup would show the new output word one cycle early or late. It changes the symbol twice inside one cycle to expose an output path that is registered instead of combinational. It drives reset together with a low advance enable to catch a design that gates reset with the enable, and it writes garbage into the unused upper data bits to catch a design that stores a truncated or shifted next-state value.

// File: rtl/tfsm_pkg.sv
package tfsm_pkg;

    typedef enum logic {
        TBL_NEXT = 1'b0,
        TBL_OUT  = 1'b1
    } tbl_sel_e;

    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned tbl_depth(input int unsigned sbits, input int unsigned ibits);
        return 32'd1 << (sbits + ibits);
    endfunction

endpackage

// File: rtl/tfsm_next_mem.sv
module tfsm_next_mem #(
    parameter int unsigned STATE_BITS = 4,
    parameter int unsigned INPUT_BITS = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             adv_en,
    input  logic [STATE_BITS+INPUT_BITS-1:0] rd_addr,
    input  logic                             we,
    input  logic [STATE_BITS+INPUT_BITS-1:0] waddr,
    input  logic [STATE_BITS-1:0]            wdata,
    output logic [STATE_BITS-1:0]            q
);
    localparam int unsigned DEPTH = tfsm_pkg::tbl_depth(STATE_BITS, INPUT_BITS);

    logic [STATE_BITS-1:0] mem [DEPTH];

    // write side
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // registered read side doubles as the state register
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (adv_en) begin
            q <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/tfsm_out_lut.sv
module tfsm_out_lut #(
    parameter int unsigned ADDR_BITS   = 6,
    parameter int unsigned OUTPUT_BITS = 8
) (
    input  logic                   clk,
    input  logic [ADDR_BITS-1:0]   rd_addr,
    input  logic                   we,
    input  logic [ADDR_BITS-1:0]   waddr,
    input  logic [OUTPUT_BITS-1:0] wdata,
    output logic [OUTPUT_BITS-1:0] rd_data
);
    localparam int unsigned DEPTH = 32'd1 << ADDR_BITS;

    logic [OUTPUT_BITS-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // zero-latency lookup
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tfsm_mealy.sv
module tfsm_mealy #(
    parameter int unsigned STATE_BITS  = 4,
    parameter int unsigned INPUT_BITS  = 2,
    parameter int unsigned OUTPUT_BITS = 8
) (
    input  logic                                                   clk,
    input  logic                                                   rst,
    input  logic                                                   adv_en,
    input  logic [INPUT_BITS-1:0]                                  sym_in,
    output logic [OUTPUT_BITS-1:0]                                 out_word,
    output logic [STATE_BITS-1:0]                                  cur_state,
    input  logic                                                   tbl_we,
    input  logic                                                   tbl_sel,
    input  logic [STATE_BITS+INPUT_BITS-1:0]                       tbl_addr,
    input  logic [tfsm_pkg::wmax(STATE_BITS, OUTPUT_BITS)-1:0]     tbl_wdata
);
    import tfsm_pkg::*;

    localparam int unsigned ADDR_BITS = STATE_BITS + INPUT_BITS;

    tbl_sel_e               sel;
    logic [ADDR_BITS-1:0]   lookup_addr;
    logic                   we_next;
    logic                   we_out;
    logic [STATE_BITS-1:0]  state_q;

    assign sel         = tbl_sel_e'(tbl_sel);
    assign we_next     = tbl_we && (sel == TBL_NEXT);
    assign we_out      = tbl_we && (sel == TBL_OUT);
    assign lookup_addr = {state_q, sym_in};

    tfsm_next_mem #(
        .STATE_BITS (STATE_BITS),
        .INPUT_BITS (INPUT_BITS)
    ) u_next (
        .clk     (clk),
        .rst     (rst),
        .adv_en  (adv_en),
        .rd_addr (lookup_addr),
        .we      (we_next),
        .waddr   (tbl_addr),
        .wdata   (tbl_wdata[STATE_BITS-1:0]),
        .q       (state_q)
    );

    tfsm_out_lut #(
        .ADDR_BITS   (ADDR_BITS),
        .OUTPUT_BITS (OUTPUT_BITS)
    ) u_out (
        .clk     (clk),
        .rd_addr (lookup_addr),
        .we      (we_out),
        .waddr   (tbl_addr),
        .wdata   (tbl_wdata[OUTPUT_BITS-1:0]),
        .rd_data (out_word)
    );

    assign cur_state = state_q;
endmodule

// File: rtl/tfsm_mealy_chk.sv
module tfsm_mealy_chk #(
    parameter int unsigned STATE_BITS  = 4,
    parameter int unsigned INPUT_BITS  = 2,
    parameter int unsigned OUTPUT_BITS = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   adv_en,
    input logic [INPUT_BITS-1:0]  sym_in,
    input logic [OUTPUT_BITS-1:0] out_word,
    input logic [STATE_BITS-1:0]  cur_state,
    input logic                   tbl_we,
    input logic                   tbl_sel
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cur_state == '0)); // R2

    AST_RESET_OVER_HOLD: assert property (@(posedge clk)
        (rst && !adv_en) |=> (cur_state == '0)); // R9

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> (cur_state == $past(cur_state))); // R5

    AST_OUT_STEADY: assert property (@(posedge clk) disable iff (rst)
        !(tbl_we && tbl_sel) ##1
        ((cur_state == $past(cur_state)) && (sym_in == $past(sym_in)))
        |-> (out_word == $past(out_word))); // R4
endmodule

bind tfsm_mealy tfsm_mealy_chk #(
    .STATE_BITS  (STATE_BITS),
    .INPUT_BITS  (INPUT_BITS),
    .OUTPUT_BITS (OUTPUT_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv_en    (adv_en),
    .sym_in    (sym_in),
    .out_word  (out_word),
    .cur_state (cur_state),
    .tbl_we    (tbl_we),
    .tbl_sel   (tbl_sel)
);

// File: tb/tfsm_mealy_bench.sv
`timescale 1ns/1ps
module tfsm_mealy_bench;
    localparam int SB = 4, IB = 2, OB = 8;
    localparam int AW = SB + IB, DEPTH = 1 << AW, DW = 8;
    localparam int NSYM = 1 << IB, NST = 1 << SB;

    logic clk = 0, rst = 1, adv_en = 0, tbl_we = 0, tbl_sel = 0;
    logic [IB-1:0] sym_in = '0;
    logic [AW-1:0] tbl_addr = '0;
    logic [DW-1:0] tbl_wdata = '0;
    logic [OB-1:0] out_word;
    logic [SB-1:0] cur_state;

    tfsm_mealy #(.STATE_BITS(SB), .INPUT_BITS(IB), .OUTPUT_BITS(OB)) u_tfsm_mealy (
        .clk(clk), .rst(rst), .adv_en(adv_en), .sym_in(sym_in),
        .out_word(out_word), .cur_state(cur_state), .tbl_we(tbl_we),
        .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata));

    always #2.5 clk = ~clk;

    int tests = 0, fails = 0;
    int m_nxt[DEPTH];
    int m_out[DEPTH];
    int m_st = 0;
    bit out_valid = 0;
    int pat[4] = '{1, 3, 2, 0};

    function automatic int gen_next(int s, int x);
        if (s < 4 && x == pat[s]) return s + 1;
        if (s >= 5) return (s + x) % NST;
        return (x == 1) ? 1 : 0;
    endfunction

    function automatic int gen_out(int s, int x);
        if (s == 3 && x == 0) return 255;
        return (s * 16 + x * 5 + 3) % 256;
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_now(string req);
        chk(req, int'(cur_state), m_st);
        if (out_valid) chk(req, int'(out_word), m_out[m_st * NSYM + int'(sym_in)]);
    endtask

    // inputs set just after a falling edge; check, take the edge, update the model
    task automatic cycle(string req);
        int ns;
        #1 check_now(req);
        @(posedge clk);
        if (rst) ns = 0;
        else if (adv_en) ns = m_nxt[m_st * NSYM + int'(sym_in)];
        else ns = m_st;
        if (tbl_we) begin
            if (tbl_sel == 1'b0) m_nxt[tbl_addr] = int'(tbl_wdata) % NST;
            else m_out[tbl_addr] = int'(tbl_wdata);
        end
        m_st = ns;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // load output table under reset (R6, R1 address layout)
        for (int a = 0; a < DEPTH; a++) begin
            tbl_we = 1; tbl_sel = 1; tbl_addr = AW'(a);
            tbl_wdata = DW'(gen_out(a / NSYM, a % NSYM));
            cycle("R2 R6");
        end
        out_valid = 1;
        // load next-state table with junk in unused upper data bits (R8)
        for (int a = 0; a < DEPTH; a++) begin
            tbl_we = 1; tbl_sel = 0; tbl_addr = AW'(a);
            tbl_wdata = {4'($urandom), 4'(gen_next(a / NSYM, a % NSYM))};
            sym_in = IB'($urandom);
            cycle("R2 R8");
        end
        tbl_we = 0;
        // run the detector (R1, R3, R4)
        rst = 0; adv_en = 1;
        for (int i = 0; i < 400; i++) begin
            if (m_st < 4 && ($urandom % 2) == 0) sym_in = IB'(pat[m_st]);
            else sym_in = IB'($urandom);
            cycle("R1 R3");
        end
        // symbol changes inside one cycle (R4)
        for (int i = 0; i < 20; i++) begin
            sym_in = IB'($urandom);
            #1 chk("R4", int'(out_word), m_out[m_st * NSYM + int'(sym_in)]);
            sym_in = IB'($urandom);
            cycle("R4");
        end
        // random hold (R5)
        for (int i = 0; i < 200; i++) begin
            adv_en = ($urandom % 2) == 1;
            sym_in = IB'($urandom);
            cycle("R5");
        end
        // same-edge collisions (R7)
        for (int i = 0; i < 10; i++) begin
            adv_en = 1; sym_in = IB'($urandom);
            tbl_we = 1; tbl_sel = 0;
            tbl_addr = {SB'(m_st), sym_in};
            tbl_wdata = DW'((m_nxt[m_st * NSYM + int'(sym_in)] + 7) % NST);
            cycle("R7");
            tbl_we = 0;
            cycle("R7");
            adv_en = 0; tbl_we = 1; tbl_sel = 1;
            tbl_addr = {SB'(m_st), sym_in};
            tbl_wdata = DW'($urandom);
            cycle("R7");
            tbl_we = 0;
            cycle("R7");
        end
        // next-state write with state held never moves the state (R6)
        for (int i = 0; i < 10; i++) begin
            adv_en = 0; tbl_we = 1; tbl_sel = 0;
            tbl_addr = {cur_state, sym_in};
            tbl_wdata = DW'($urandom);
            cycle("R6");
        end
        // random mixed writes and traffic (R6, R8)
        for (int i = 0; i < 200; i++) begin
            adv_en = ($urandom % 4) != 0;
            sym_in = IB'($urandom);
            tbl_we = ($urandom % 3) == 0;
            tbl_sel = 1'($urandom);
            tbl_addr = AW'($urandom);
            tbl_wdata = DW'($urandom);
            cycle("R6 R8");
        end
        tbl_we = 0;
        // reset wins over hold (R9)
        for (int i = 0; i < 5; i++) begin
            adv_en = 1; sym_in = IB'($urandom);
            cycle("R9");
            rst = 1; adv_en = 0;
            cycle("R9");
            cycle("R9 R2");
            rst = 0;
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule